// File: doc/BRIEF.md
# Operand Specifier Address Generator

This unit turns one decoded operand specifier into the location of the operand. The specifier gives an addressing-mode code, a base register number, an optional index register, a displacement or short literal, and the operand size. The unit reads the 16 x 32-bit general register file through two combinational read ports. It writes back the base register when the mode auto-modifies it. For the pointer-through-memory modes it issues one longword read on a request/response port. When it finishes it reports an effective address, a literal value or the number of a register that holds the operand.

A request is a one-cycle `start` pulse with all specifier fields valid in that cycle. Modes that need no memory finish one cycle later. Pointer modes hold `busy` until the memory response arrives. Index mode adds the index register, shifted left by the size code, to whatever address the base mode produced. Illegal combinations end as a fault and not as an address. All address arithmetic wraps modulo 2^32. Register 15 holds the program counter and is handled like any other base register.

Top module: `opnd_addr_gen`

## Requirements
- R1: Mode code 0 (register) completes with `kind`=2 and with `ea` equal to the zero-extended base register number, and it writes no register.
- R2: Mode 1 gives `ea` = base register value. Mode 5 gives `ea` = base + displacement, where `disp_sel` 0 sign-extends `disp[7:0]`, 1 sign-extends `disp[15:0]` and 2 or 3 takes all 32 bits, and the sum wraps modulo 2^32. Both modes report `kind`=0.
- R3: Mode 2 gives `ea` = base value and writes base + size back to the base register. The size in bytes is 1 << `size_code`, so codes 0..4 mean 1, 2, 4, 8 and 16.
- R4: Mode 4 writes base - size back to the base register and gives that decreased value as `ea`.
- R5: Mode 3 reads the longword at the base value. `ea` is the returned data, and the base register is written with base + 4 whatever the size.
- R6: Mode 6 reads the longword at base + sign-extended displacement, and `ea` is the returned data.
- R7: Mode 7 (literal) completes with `kind`=1, `ea` = zero-extended `disp[5:0]`, and no memory request and no register write.
- R8: With `idx_en`=1 the final `ea` is the base-mode address plus (index register value << `size_code`). For modes 3 and 6 the index term is added to the fetched pointer.
- R9: These combinations complete with `fault`=1, `ea`=0, no register write and no memory request: mode codes 8..15; `size_code` above 4; index with mode 0 or 7; and index with modes 2, 3 or 4 when the index register number equals the base register number.
- R10: Non-pointer requests raise `done` in the cycle after `start`. A write-back appears as a one-cycle `rf_we` in the cycle after `start`. Pointer requests hold `mem_req` with a stable `mem_addr` until `mem_rvalid`, and `done` follows in the next cycle.
- R11: A `start` while `busy` is high is ignored: it produces no write-back and does not disturb the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; specifier fields are valid with it |
| mode | input | 4 | Addressing mode code (0..7 legal) |
| rn | input | 4 | Base register number |
| idx_en | input | 1 | Index mode enable |
| rx | input | 4 | Index register number |
| size_code | input | 3 | log2 of the operand size in bytes (0..4 legal) |
| disp_sel | input | 2 | Displacement width: 0 byte, 1 word, 2/3 longword |
| disp | input | 32 | Displacement or literal (low 6 bits) |
| rf_ra | output | 4 | Register file read address A (base) |
| rf_rda | input | 32 | Register file read data A |
| rf_rb | output | 4 | Register file read address B (index) |
| rf_rdb | input | 32 | Register file read data B |
| rf_we | output | 1 | Register write-back strobe |
| rf_waddr | output | 4 | Write-back register number |
| rf_wdata | output | 32 | Write-back value |
| mem_req | output | 1 | Pointer read request, held until response |
| mem_addr | output | 32 | Pointer read address |
| mem_rvalid | input | 1 | Pointer read response valid |
| mem_rdata | input | 32 | Pointer read data |
| busy | output | 1 | Waiting for the pointer response |
| done | output | 1 | Result valid for one cycle |
| fault | output | 1 | Reserved-addressing fault, valid with done |
| kind | output | 2 | Result class: 0 address, 1 literal, 2 register |
| ea | output | 32 | Effective address, literal or register number |

## Verification
The assertions check the memory handshake on every cycle: the request and its address stay put until the response, and a response is always followed by a fault-free `done`. They also check that a faulting result never comes with a register write, that every write-back traces to an accepted `start` and targets its base register, that a `start` during `busy` never writes, and that a literal result stays below 64. The address values themselves can only be shown by the bench's scenarios. These cover each mode's arithmetic, sign extension of byte and word displacements, wrap-around, size scaling of auto-modify and index terms, varying memory latency and the full set of fault conditions.

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
  parameter int AW    = 32,
  parameter int NREG  = 16,
  parameter int LIT_W = 6,
  parameter int MAXSZ = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [3:0]              mode,
  input  logic [$clog2(NREG)-1:0] rn,
  input  logic                    idx_en,
  input  logic [$clog2(NREG)-1:0] rx,
  input  logic [2:0]              size_code,
  input  logic [1:0]              disp_sel,
  input  logic [AW-1:0]           disp,
  output logic [$clog2(NREG)-1:0] rf_ra,
  input  logic [AW-1:0]           rf_rda,
  output logic [$clog2(NREG)-1:0] rf_rb,
  input  logic [AW-1:0]           rf_rdb,
  output logic                    rf_we,
  output logic [$clog2(NREG)-1:0] rf_waddr,
  output logic [AW-1:0]           rf_wdata,
  output logic                    mem_req,
  output logic [AW-1:0]           mem_addr,
  input  logic                    mem_rvalid,
  input  logic [AW-1:0]           mem_rdata,
  output logic                    busy,
  output logic                    done,
  output logic                    fault,
  output logic [1:0]              kind,
  output logic [AW-1:0]           ea
);
  localparam int RW = $clog2(NREG);
  localparam logic [3:0] M_REG = 4'd0, M_RDEF = 4'd1, M_AINC = 4'd2, M_AIDF = 4'd3,
                         M_ADEC = 4'd4, M_DISP = 4'd5, M_DDEF = 4'd6, M_LIT = 4'd7;
  localparam logic [1:0] K_ADDR = 2'd0, K_LIT = 2'd1, K_REG = 2'd2;
  localparam logic [AW-1:0] PTR_BYTES = AW'(4);

  logic          waiting;
  logic          done_q, fault_q, we_q;
  logic [1:0]    kind_q;
  logic [AW-1:0] ea_q, idx_q, maddr_q, wd_q;
  logic [RW-1:0] wa_q;

  logic [AW-1:0] size_b, dext, sum_disp, idx_term, direct_c, ptr_c, wval_c;
  logic [1:0]    kind_c;
  logic          defer_c, wr_c, automod, bad;

  assign rf_ra = rn;
  assign rf_rb = rx;

  assign size_b   = AW'(1) << size_code;
  assign idx_term = rf_rdb << size_code;
  assign sum_disp = rf_rda + dext;
  assign automod  = (mode == M_AINC) || (mode == M_AIDF) || (mode == M_ADEC);
  assign defer_c  = (mode == M_AIDF) || (mode == M_DDEF);

  always_comb begin
    case (disp_sel)
      2'd0:    dext = {{(AW-8){disp[7]}}, disp[7:0]};
      2'd1:    dext = {{(AW-16){disp[15]}}, disp[15:0]};
      default: dext = disp;
    endcase
  end

  assign bad = mode[3]
             || (size_code > 3'(MAXSZ))
             || (idx_en && (mode == M_REG || mode == M_LIT))
             || (idx_en && automod && (rx == rn));

  always_comb begin
    direct_c = rf_rda;
    ptr_c    = rf_rda;
    wval_c   = rf_rda;
    wr_c     = 1'b0;
    kind_c   = K_ADDR;
    case (mode)
      M_REG:  begin direct_c = AW'(rn); kind_c = K_REG; end
      M_AINC: begin wval_c = rf_rda + size_b; wr_c = 1'b1; end
      M_AIDF: begin wval_c = rf_rda + PTR_BYTES; wr_c = 1'b1; end
      M_ADEC: begin wval_c = rf_rda - size_b; direct_c = wval_c; wr_c = 1'b1; end
      M_DISP: direct_c = sum_disp;
      M_DDEF: ptr_c = sum_disp;
      M_LIT:  begin direct_c = AW'(disp[LIT_W-1:0]); kind_c = K_LIT; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      we_q    <= 1'b0;
      kind_q  <= K_ADDR;
      ea_q    <= '0;
      idx_q   <= '0;
      maddr_q <= '0;
      wd_q    <= '0;
      wa_q    <= '0;
    end else begin
      done_q <= 1'b0;
      we_q   <= 1'b0;
      if (!waiting) begin
        if (start) begin
          fault_q <= bad;
          kind_q  <= bad ? K_ADDR : kind_c;
          we_q    <= wr_c && !bad;
          wa_q    <= rn;
          wd_q    <= wval_c;
          if (defer_c && !bad) begin
            waiting <= 1'b1;
            maddr_q <= ptr_c;
            idx_q   <= idx_en ? idx_term : '0;
          end else begin
            done_q <= 1'b1;
            ea_q   <= bad ? '0 : direct_c + (idx_en ? idx_term : '0);
          end
        end
      end else if (mem_rvalid) begin
        waiting <= 1'b0;
        done_q  <= 1'b1;
        ea_q    <= mem_rdata + idx_q;
      end
    end
  end

  assign busy     = waiting;
  assign mem_req  = waiting;
  assign mem_addr = maddr_q;
  assign done     = done_q;
  assign fault    = done_q & fault_q;
  assign kind     = kind_q;
  assign ea       = ea_q;
  assign rf_we    = we_q;
  assign rf_waddr = wa_q;
  assign rf_wdata = wd_q;

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));
  assert_resp_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid |=> done && !fault);
  assert_fault_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !rf_we && !mem_req);
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> !rf_we);
  assert_wb_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(start) && rf_waddr == $past(rn));
  assert_lit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && kind == K_LIT |-> ea < AW'(1 << LIT_W));
endmodule

// File: tb/tb_opnd_addr_gen.sv
module tb_opnd_addr_gen;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, idx_en = 0;
  logic [3:0]  mode = 0, rn = 0, rx = 0;
  logic [2:0]  size_code = 0;
  logic [1:0]  disp_sel = 0;
  logic [31:0] disp = 0;
  logic [3:0]  rf_ra, rf_rb, rf_waddr;
  logic [31:0] rf_rda, rf_rdb, rf_wdata, mem_addr, ea;
  logic        rf_we, mem_req, busy, done, fault;
  logic        mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;
  logic [1:0]  kind;

  logic [31:0] regs [16];
  int checks = 0, fails = 0, mem_delay = 0, mcnt = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  opnd_addr_gen dut (.*);

  assign rf_rda = regs[rf_ra];
  assign rf_rdb = regs[rf_rb];

  always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  always @(negedge clk) begin
    if (mem_req && !mem_rvalid) begin
      if (mcnt >= mem_delay) begin
        mem_rvalid = 1; mem_rdata = memf(mem_addr); mcnt = 0;
      end else mcnt++;
    end else mem_rvalid = 0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] e_ea, e_wval;
  logic [1:0]  e_kind;
  bit          e_fault, e_we, e_def;

  task automatic calc(input logic [3:0] m, input logic [3:0] b, input bit ix, input logic [3:0] x,
                      input logic [2:0] sc, input logic [1:0] ds, input logic [31:0] d);
    logic [31:0] bv, sz, dx;
    bv = regs[b]; sz = 32'd1 << sc;
    dx = (ds == 0) ? {{24{d[7]}}, d[7:0]} : (ds == 1) ? {{16{d[15]}}, d[15:0]} : d;
    e_fault = m > 7 || sc > 4 || (ix && (m == 0 || m == 7)) ||
              (ix && x == b && (m == 2 || m == 3 || m == 4));
    e_kind = 0; e_we = 0; e_wval = bv; e_def = 0; e_ea = 0;
    if (!e_fault) begin
      case (m)
        0: begin e_kind = 2; e_ea = {28'd0, b}; end
        1: e_ea = bv;
        2: begin e_ea = bv; e_we = 1; e_wval = bv + sz; end
        3: begin e_ea = memf(bv); e_we = 1; e_wval = bv + 4; e_def = 1; end
        4: begin e_ea = bv - sz; e_we = 1; e_wval = bv - sz; end
        5: e_ea = bv + dx;
        6: begin e_ea = memf(bv + dx); e_def = 1; end
        default: begin e_kind = 1; e_ea = {26'd0, d[5:0]}; end
      endcase
      if (ix) e_ea = e_ea + (regs[x] << sc);
    end
  endtask

  function automatic string rtag(input logic [3:0] m, input bit ix, input bit f);
    if (f) return "R9";
    if (ix) return "R8";
    case (m)
      0: return "R1"; 1, 5: return "R2"; 2: return "R3"; 3: return "R5";
      4: return "R4"; 6: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] m, input logic [3:0] b, input bit ix, input logic [3:0] x,
                        input logic [2:0] sc, input logic [1:0] ds, input logic [31:0] d);
    logic [31:0] e_reg; string t; int n;
    @(negedge clk);
    mode = m; rn = b; idx_en = ix; rx = x; size_code = sc; disp_sel = ds; disp = d;
    calc(m, b, ix, x, sc, ds, d);
    e_reg = e_we ? e_wval : regs[b];
    t = rtag(m, ix, e_fault);
    start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    chk(done, "R10 done seen", {31'd0, done}, 32'd1);
    if (!e_def) chk(n == 0, "R10 single-cycle latency", n, 0);
    chk(ea == e_ea, {t, " ea"}, ea, e_ea);
    chk(kind == e_kind, {t, " kind"}, {30'd0, kind}, {30'd0, e_kind});
    chk(fault == e_fault, {t, " fault"}, {31'd0, fault}, {31'd0, e_fault});
    @(negedge clk);
    chk(regs[b] == e_reg, {t, " base register after op"}, regs[b], e_reg);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + 32'(i) * 32'h111;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && !busy && !rf_we, "reset outputs idle",
        {28'd0, done, mem_req, busy, rf_we}, 0);
    rst_n = 1;
    @(negedge clk);
    run_op(0, 9, 0, 0, 2, 0, 0);                   // R1
    run_op(1, 3, 0, 0, 0, 0, 0);                   // R2
    run_op(5, 4, 0, 0, 2, 0, 32'h0000_00F0);       // R2 negative byte
    run_op(5, 4, 0, 0, 2, 1, 32'h0000_8004);       // R2 negative word
    regs[6] = 32'hFFFF_FFF0;
    run_op(5, 6, 0, 0, 2, 2, 32'h0000_0020);       // R2 wrap
    run_op(2, 5, 0, 0, 4, 0, 0);                   // R3 size 16
    run_op(2, 5, 0, 0, 0, 0, 0);                   // R3 size 1
    regs[7] = 32'h0000_0004;
    run_op(4, 7, 0, 0, 3, 0, 0);                   // R4 wraps below zero
    run_op(3, 8, 0, 0, 4, 0, 0);                   // R5 always +4
    mem_delay = 3;
    run_op(6, 2, 0, 0, 2, 0, 32'h0000_0080);       // R6
    run_op(7, 1, 0, 0, 2, 0, 32'hFFFF_FFEA);       // R7
    run_op(5, 2, 1, 3, 3, 1, 32'h0000_0100);       // R8
    run_op(6, 2, 1, 3, 1, 0, 32'h0000_0010);       // R8 on fetched pointer
    run_op(4, 5, 1, 6, 2, 0, 0);                   // R8 with autodecrement
    run_op(2, 5, 1, 5, 2, 0, 0);                   // R9 same register
    run_op(3, 8, 1, 8, 2, 0, 0);                   // R9 same register deferred
    run_op(7, 1, 1, 2, 2, 0, 5);                   // R9 index literal
    run_op(11, 1, 0, 0, 2, 0, 0);                  // R9 reserved mode
    run_op(2, 1, 0, 0, 5, 0, 0);                   // R9 bad size
    // R11: start while busy
    begin
      logic [31:0] e_r10, e_a; int n;
      mem_delay = 6;
      @(negedge clk);
      mode = 6; rn = 2; idx_en = 0; size_code = 2; disp_sel = 2; disp = 32'h40;
      calc(6, 2, 0, 0, 2, 2, 32'h40); e_a = e_ea;
      start = 1; @(negedge clk); start = 0;
      @(negedge clk);
      e_r10 = regs[10];
      mode = 2; rn = 10; size_code = 2; start = 1; @(negedge clk); start = 0;
      n = 0;
      while (!done && n < 60) begin @(negedge clk); n++; end
      chk(ea == e_a, "R11 in-flight ea kept", ea, e_a);
      @(negedge clk); @(negedge clk);
      chk(regs[10] == e_r10, "R11 ignored start wrote nothing", regs[10], e_r10);
      chk(!done && !busy, "R11 no second completion", {30'd0, done, busy}, 0);
    end
    for (int k = 0; k < 400; k++) begin
      logic [3:0] m;
      m = ($urandom % 20 == 0) ? 4'(8 + $urandom % 8) : 4'($urandom % 8);
      mem_delay = $urandom % 4;
      run_op(m, 4'($urandom), ($urandom % 4) == 0, 4'($urandom),
             3'(($urandom % 12 == 0) ? 5 + $urandom % 3 : $urandom % 5),
             2'($urandom), $urandom);
    end
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule